// File: doc/BRIEF.md
# Vectored Fast/Normal Interrupt Controller

This block arbitrates interrupt sources for a 16-bit processor core. It handles one fast request line, a bank of level-sensitive normal request lines, a software trap request and reset. The core marks each instruction boundary with a one-cycle pulse. Requests are sampled only on that pulse. When a source wins arbitration, the block emits a one-cycle take pulse. It also presents the page-0 address of the vector slot from which the core fetches the 16-bit handler address, so the core must clear its code segment to 0 when it sees the take pulse.

The block owns the fast-enable and normal-enable bits, a nesting mode bit and a current service level. It decodes the enable-control commands the core issues. At every entry it saves the enable state and level on a small internal stack. A return-from-interrupt request pops that stack and puts the saved enables back. In nesting mode the level is restored as well, and the block raises strobes that tell the core to stack or unstack its wider flags word.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high (synchronous), the fast enable, normal enable and nesting bits, and the level, are cleared. `take_o` and `ret_o` are low, and `vec_o` holds the reset slot 0xFFF7.
- R2: When `cmd_vld_i` is high, `cmd_i` takes effect at the next edge. The codes are: 0 clears normal enable; 1 sets normal enable; 2 clears fast enable; 3 sets fast enable; 4 clears both; 5 sets normal enable and clears fast enable; 6 sets fast enable and clears normal enable; 7 sets both; 8 turns nesting off; 9 turns nesting on; 10 loads `lvl_i` into the level. Codes 11 to 15 change nothing.
- R3: A source is taken only in a cycle where `boundary_i` is high. The registered `take_o` pulse and the new `vec_o` appear at the following edge. Requests present without a boundary pulse are not taken.
- R4: When several sources are eligible at once, the fast request wins first, then the software trap, then normal line 0 down to line 7. The slots are: trap 0xFFF5, fast 0xFFF6, reset 0xFFF7, and normal line k at 0xFFF8+k.
- R5: The software trap is taken whatever the enable bits are, and taking it leaves both enable bits unchanged.
- R6: The fast request is taken only while fast enable is 1, and taking it clears fast enable.
- R7: Outside nesting mode, a normal line is taken only while normal enable is 1, and taking it clears normal enable.
- R8: In nesting mode, normal line k has level 8-k and is taken only if normal enable is 1 and its level is strictly above the current level. Taking it loads that level and leaves normal enable at 1. Any take in nesting mode pulses `flag_save_o` together with `take_o`.
- R9: With `reti_i` high and no take in the same cycle, `ret_o` pulses and the enable bits return to the values they held just before the most recent unreturned entry. In nesting mode the level is restored as well, and `flag_rest_o` pulses.
- R10: A return while no entry is outstanding still pulses `ret_o` but leaves the enable bits and level unchanged.
- R11: In a cycle where a source is taken, any command or return presented at the same time has no effect.
- R12: `vec_o` changes only at a take and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary pulse; requests are sampled here |
| fast_req_i | input | 1 | Fast interrupt request (level) |
| brk_req_i | input | 1 | Software trap request |
| irq_req_i | input | NUM_IRQ | Normal interrupt request lines (level), line 0 highest |
| cmd_vld_i | input | 1 | Enable-control command strobe |
| cmd_i | input | 4 | Enable-control command code |
| lvl_i | input | LVL_W | Level value for the level-load command |
| reti_i | input | 1 | Return-from-interrupt request |
| take_o | output | 1 | One-cycle pulse: a source was taken |
| ret_o | output | 1 | One-cycle pulse: a return was performed |
| flag_save_o | output | 1 | Entry in nesting mode: core stacks its flags word |
| flag_rest_o | output | 1 | Return in nesting mode: core unstacks its flags word |
| vec_o | output | 16 | Page-0 vector slot address |
| fast_en_o | output | 1 | Fast enable bit |
| irq_en_o | output | 1 | Normal enable bit |
| nest_o | output | 1 | Nesting mode bit |
| lvl_o | output | LVL_W | Current service level |

## Verification
The bench presents the fast request, the trap and two normal lines together, so a design that reordered priority would emit the wrong slot. It issues a command and a request in the same boundary cycle. A design that let the command through would show changed enable bits after the take. It returns through three stacked entries and then once more with nothing left, so a design that popped in the wrong order or disturbed the flags on an empty return would show different enables. In nesting mode it raises a lower-level line while a higher one is in service; a design that compared with `>=` or cleared the normal enable would take it or drop the enable.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [3:0] {
    CMD_IRQ_DIS   = 4'd0,
    CMD_IRQ_ENA   = 4'd1,
    CMD_FAST_DIS  = 4'd2,
    CMD_FAST_ENA  = 4'd3,
    CMD_ALL_DIS   = 4'd4,
    CMD_ONLY_IRQ  = 4'd5,
    CMD_ONLY_FAST = 4'd6,
    CMD_ALL_ENA   = 4'd7,
    CMD_NEST_DIS  = 4'd8,
    CMD_NEST_ENA  = 4'd9,
    CMD_LEVEL_LD  = 4'd10
  } ctl_cmd_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FAST = 2'd1,
    SRC_BRK  = 2'd2,
    SRC_IRQ  = 2'd3
  } src_e;

endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 4,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               fast_req,
  input  logic               fast_en,
  input  logic               brk_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               irq_en,
  input  logic               nest_en,
  input  logic [LVL_W-1:0]   cur_lvl,
  output src_e               src,
  output logic [IDX_W-1:0]   idx,
  output logic [LVL_W-1:0]   lvl
);

  logic [NUM_IRQ-1:0] elig;

  // Each line carries a fixed level: line 0 is the highest.
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    localparam logic [LVL_W-1:0] LINE_LVL = LVL_W'(NUM_IRQ - k);
    assign elig[k] = irq_req[k] & irq_en & (~nest_en | (LINE_LVL > cur_lvl));
  end

  always_comb begin
    idx = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (elig[k]) idx = IDX_W'(k);
    end
    lvl = LVL_W'(NUM_IRQ) - LVL_W'(idx);
    if (fast_req && fast_en)  src = SRC_FAST;
    else if (brk_req)         src = SRC_BRK;
    else if (|elig)           src = SRC_IRQ;
    else                      src = SRC_NONE;
  end

endmodule

// File: rtl/irqv_save_stack.sv
module irqv_save_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 6,
  localparam int AW    = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] top_idx;
  logic             full;

  assign full    = (ptr == PTR_W'(DEPTH));
  assign empty   = (ptr == '0);
  assign top_idx = ptr - 1'b1;
  assign dout    = mem[top_idx[AW-1:0]];

  // Storage has no reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push && !full) mem[ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                 ptr <= '0;
    else if (push && !full)  ptr <= ptr + 1'b1;
    else if (pop && !empty)  ptr <= ptr - 1'b1;
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int          NUM_IRQ  = 8,
  parameter int          LVL_W    = 4,
  parameter int          DEPTH    = 4,
  parameter logic [15:0] VEC_BASE = 16'hFFF5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boundary_i,
  input  logic               fast_req_i,
  input  logic               brk_req_i,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic               cmd_vld_i,
  input  logic [3:0]         cmd_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               reti_i,
  output logic               take_o,
  output logic               ret_o,
  output logic               flag_save_o,
  output logic               flag_rest_o,
  output logic [15:0]        vec_o,
  output logic               fast_en_o,
  output logic               irq_en_o,
  output logic               nest_o,
  output logic [LVL_W-1:0]   lvl_o
);

  localparam int          IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int          ENT_W    = 2 + LVL_W;
  localparam logic [15:0] VEC_BRK  = VEC_BASE;
  localparam logic [15:0] VEC_FAST = VEC_BASE + 16'd1;
  localparam logic [15:0] VEC_RST  = VEC_BASE + 16'd2;
  localparam logic [15:0] VEC_IRQ0 = VEC_BASE + 16'd3;

  src_e             src;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             grant;
  logic             do_ret;
  logic [ENT_W-1:0] save_din;
  logic [ENT_W-1:0] save_dout;
  logic             save_empty;

  irqv_arbiter #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_arb (
    .fast_req (fast_req_i),
    .fast_en  (fast_en_o),
    .brk_req  (brk_req_i),
    .irq_req  (irq_req_i),
    .irq_en   (irq_en_o),
    .nest_en  (nest_o),
    .cur_lvl  (lvl_o),
    .src      (src),
    .idx      (win_idx),
    .lvl      (win_lvl)
  );

  assign grant    = boundary_i && (src != SRC_NONE);
  assign do_ret   = reti_i && !grant;
  assign save_din = {fast_en_o, irq_en_o, lvl_o};

  irqv_save_stack #(.DEPTH(DEPTH), .W(ENT_W)) u_stk (
    .clk   (clk),
    .rst   (rst),
    .push  (grant),
    .pop   (do_ret),
    .din   (save_din),
    .dout  (save_dout),
    .empty (save_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_en_o   <= 1'b0;
      irq_en_o    <= 1'b0;
      nest_o      <= 1'b0;
      lvl_o       <= '0;
      vec_o       <= VEC_RST;
      take_o      <= 1'b0;
      ret_o       <= 1'b0;
      flag_save_o <= 1'b0;
      flag_rest_o <= 1'b0;
    end else begin
      take_o      <= 1'b0;
      ret_o       <= 1'b0;
      flag_save_o <= 1'b0;
      flag_rest_o <= 1'b0;
      if (grant) begin
        take_o      <= 1'b1;
        flag_save_o <= nest_o;
        unique case (src)
          SRC_FAST: begin
            vec_o     <= VEC_FAST;
            fast_en_o <= 1'b0;
          end
          SRC_BRK: vec_o <= VEC_BRK;
          default: begin
            vec_o <= VEC_IRQ0 + 16'(win_idx);
            if (nest_o) lvl_o    <= win_lvl;
            else        irq_en_o <= 1'b0;
          end
        endcase
      end else if (do_ret) begin
        ret_o       <= 1'b1;
        flag_rest_o <= nest_o;
        if (!save_empty) begin
          fast_en_o <= save_dout[ENT_W-1];
          irq_en_o  <= save_dout[ENT_W-2];
          if (nest_o) lvl_o <= save_dout[LVL_W-1:0];
        end
      end else if (cmd_vld_i) begin
        case (cmd_i)
          CMD_IRQ_DIS:   irq_en_o  <= 1'b0;
          CMD_IRQ_ENA:   irq_en_o  <= 1'b1;
          CMD_FAST_DIS:  fast_en_o <= 1'b0;
          CMD_FAST_ENA:  fast_en_o <= 1'b1;
          CMD_ALL_DIS:   begin fast_en_o <= 1'b0; irq_en_o <= 1'b0; end
          CMD_ONLY_IRQ:  begin fast_en_o <= 1'b0; irq_en_o <= 1'b1; end
          CMD_ONLY_FAST: begin fast_en_o <= 1'b1; irq_en_o <= 1'b0; end
          CMD_ALL_ENA:   begin fast_en_o <= 1'b1; irq_en_o <= 1'b1; end
          CMD_NEST_DIS:  nest_o <= 1'b0;
          CMD_NEST_ENA:  nest_o <= 1'b1;
          CMD_LEVEL_LD:  lvl_o  <= lvl_i;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int          NUM_IRQ  = 8,
  parameter int          LVL_W    = 4,
  parameter logic [15:0] VEC_BASE = 16'hFFF5
) (
  input logic             clk,
  input logic             rst,
  input logic             boundary_i,
  input logic             take_o,
  input logic             ret_o,
  input logic [15:0]      vec_o,
  input logic             fast_en_o,
  input logic             irq_en_o,
  input logic             nest_o,
  input logic [LVL_W-1:0] lvl_o
);

  localparam logic [15:0] VEC_BRK  = VEC_BASE;
  localparam logic [15:0] VEC_FAST = VEC_BASE + 16'd1;
  localparam logic [15:0] VEC_RST  = VEC_BASE + 16'd2;
  localparam logic [15:0] VEC_IRQ0 = VEC_BASE + 16'd3;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!fast_en_o && !irq_en_o && !nest_o && lvl_o == '0 &&
             vec_o == VEC_RST && !take_o && !ret_o));

  a_r3_take_on_boundary: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(boundary_i));

  a_r5_trap_keeps_enables: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o == VEC_BRK) |->
      (fast_en_o == $past(fast_en_o) && irq_en_o == $past(irq_en_o)));

  a_r6_fast_clears_enable: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o == VEC_FAST) |-> !fast_en_o);

  a_r7_irq_clears_enable: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o >= VEC_IRQ0 && !nest_o) |-> !irq_en_o);

  a_r8_nest_keeps_enable: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o >= VEC_IRQ0 && nest_o) |-> irq_en_o);

  a_r11_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_o, ret_o}));

  a_r12_vector_holds: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> $stable(vec_o));

endmodule

bind irq_vector_ctrl irqv_checker #(
  .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .boundary_i (boundary_i),
  .take_o     (take_o),
  .ret_o      (ret_o),
  .vec_o      (vec_o),
  .fast_en_o  (fast_en_o),
  .irq_en_o   (irq_en_o),
  .nest_o     (nest_o),
  .lvl_o      (lvl_o)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

  localparam int NUM_IRQ = 8;
  localparam int LVL_W   = 4;
  localparam int DEPTH   = 4;

  typedef struct packed {
    logic             take;
    logic             ret;
    logic             fsave;
    logic             frest;
    logic             fen;
    logic             ien;
    logic             nest;
    logic [LVL_W-1:0] lvl;
    logic [15:0]      vec;
  } obs_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary_i = 1'b0, fast_req_i = 1'b0, brk_req_i = 1'b0;
  logic [NUM_IRQ-1:0] irq_req_i = '0;
  logic cmd_vld_i = 1'b0;
  logic [3:0] cmd_i = '0;
  logic [LVL_W-1:0] lvl_i = '0;
  logic reti_i = 1'b0;
  logic take_o, ret_o, flag_save_o, flag_rest_o;
  logic [15:0] vec_o;
  logic fast_en_o, irq_en_o, nest_o;
  logic [LVL_W-1:0] lvl_o;

  int n_chk = 0;
  int n_bad = 0;

  obs_t  exp_q [$];
  string tag_q [$];

  // reference state
  logic             m_f = 0, m_i = 0, m_nest = 0;
  logic [LVL_W-1:0] m_lvl = '0;
  logic [15:0]      m_vec = 16'hFFF7;
  logic [5:0]       m_stk [$];

  always #2 clk = ~clk;

  irq_vector_ctrl #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .fast_req_i(fast_req_i),
    .brk_req_i(brk_req_i), .irq_req_i(irq_req_i), .cmd_vld_i(cmd_vld_i),
    .cmd_i(cmd_i), .lvl_i(lvl_i), .reti_i(reti_i), .take_o(take_o),
    .ret_o(ret_o), .flag_save_o(flag_save_o), .flag_rest_o(flag_rest_o),
    .vec_o(vec_o), .fast_en_o(fast_en_o), .irq_en_o(irq_en_o),
    .nest_o(nest_o), .lvl_o(lvl_o)
  );

  function automatic obs_t sample();
    return '{take_o, ret_o, flag_save_o, flag_rest_o, fast_en_o, irq_en_o,
             nest_o, lvl_o, vec_o};
  endfunction

  task automatic check(input string tag, input obs_t act, input obs_t exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected outcome.
  task automatic step(input string tag, input logic bnd, input logic fq,
                      input logic bq, input logic [NUM_IRQ-1:0] iq,
                      input logic cv, input logic [3:0] cc,
                      input logic [LVL_W-1:0] lv, input logic rt);
    obs_t e;
    int   win;
    @(negedge clk);
    boundary_i = bnd; fast_req_i = fq; brk_req_i = bq; irq_req_i = iq;
    cmd_vld_i = cv; cmd_i = cc; lvl_i = lv; reti_i = rt;
    e = '0;
    win = -1;
    if (bnd) begin
      if (fq && m_f) win = 100;
      else if (bq) win = 200;
      else
        for (int k = NUM_IRQ - 1; k >= 0; k--)
          if (iq[k] && m_i && (!m_nest || (NUM_IRQ - k) > int'(m_lvl))) win = k;
    end
    if (win >= 0) begin
      if (m_stk.size() < DEPTH) m_stk.push_back({m_f, m_i, m_lvl});
      e.take = 1; e.fsave = m_nest;
      if (win == 100) begin m_vec = 16'hFFF6; m_f = 0; end
      else if (win == 200) m_vec = 16'hFFF5;
      else begin
        m_vec = 16'hFFF8 + 16'(win);
        if (m_nest) m_lvl = LVL_W'(NUM_IRQ - win);
        else m_i = 0;
      end
    end else if (rt) begin
      e.ret = 1; e.frest = m_nest;
      if (m_stk.size() > 0) begin
        logic [5:0] t;
        t = m_stk.pop_back();
        m_f = t[5]; m_i = t[4];
        if (m_nest) m_lvl = t[3:0];
      end
    end else if (cv) begin
      case (cc)
        4'd0: m_i = 0;
        4'd1: m_i = 1;
        4'd2: m_f = 0;
        4'd3: m_f = 1;
        4'd4: begin m_f = 0; m_i = 0; end
        4'd5: begin m_f = 0; m_i = 1; end
        4'd6: begin m_f = 1; m_i = 0; end
        4'd7: begin m_f = 1; m_i = 1; end
        4'd8: m_nest = 0;
        4'd9: m_nest = 1;
        4'd10: m_lvl = lv;
        default: ;
      endcase
    end
    e.fen = m_f; e.ien = m_i; e.nest = m_nest; e.lvl = m_lvl; e.vec = m_vec;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare one queued item after every edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(tag_q.pop_front(), sample(), exp_q.pop_front());
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    obs_t r;
    repeat (3) @(posedge clk);
    #1;
    r = '0; r.vec = 16'hFFF7;
    check("R1 reset state", sample(), r);
    @(negedge clk); rst = 1'b0;

    step("R3 request without boundary", 0, 1, 1, 8'h01, 0, 0, 0, 0);
    step("R7 line masked by enable", 1, 0, 0, 8'h01, 0, 0, 0, 0);
    step("R2 code 7 sets both", 0, 0, 0, 0, 1, 4'd7, 0, 0);
    step("R4 R6 fast wins all", 1, 1, 1, 8'h28, 0, 0, 0, 0);
    step("R4 R5 trap over lines", 1, 0, 1, 8'h28, 0, 0, 0, 0);
    step("R4 R7 line 3 over 5", 1, 0, 0, 8'h28, 0, 0, 0, 0);
    step("R12 vector holds", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9 return from line", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9 return from trap", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9 return from fast", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R10 empty return", 0, 0, 0, 0, 0, 0, 0, 1);
    for (int c = 0; c < 16; c++)
      step("R2 command code", 0, 0, 0, 0, 1, 4'(c), 4'd0, 0);
    step("R2 code 7 again", 0, 0, 0, 0, 1, 4'd7, 0, 0);
    step("R11 command with take", 1, 0, 0, 8'h02, 1, 4'd4, 0, 0);
    step("R11 return with take", 1, 0, 1, 0, 0, 0, 0, 1);
    step("R9 return", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9 return", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R2 nesting on", 0, 0, 0, 0, 1, 4'd9, 0, 0);
    step("R2 level load", 0, 0, 0, 0, 1, 4'd10, 4'd0, 0);
    step("R8 line 6 enters", 1, 0, 0, 8'h40, 0, 0, 0, 0);
    step("R8 line 7 blocked", 1, 0, 0, 8'h80, 0, 0, 0, 0);
    step("R8 equal level blocked", 1, 0, 0, 8'h40, 0, 0, 0, 0);
    step("R8 line 2 nests", 1, 0, 0, 8'h44, 0, 0, 0, 0);
    step("R9 nested return", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9 outer return", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R2 nesting off", 0, 0, 0, 0, 1, 4'd8, 0, 0);
    step("R2 all off", 0, 0, 0, 0, 1, 4'd4, 0, 0);
    step("R5 trap while masked", 1, 1, 1, 8'hFF, 0, 0, 0, 0);
    step("R6 fast masked", 1, 1, 0, 0, 0, 0, 0, 0);
    step("R12 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule